// File: doc/BRIEF.md
# Atomic Word Access Bridge for a 16-bit Timer

This block sits between an 8-bit register bus and the core of a 16-bit timer. Two of the timer's registers, the running count and the top/capture value, must be seen as whole 16-bit words even though the bus moves a single byte per access. The bridge makes this work with one temporary byte that both word registers share. Reading a low byte returns the live low half and, on the same clock edge, copies the live high half into the temporary byte. A later high-byte read returns that copy. Writing a high byte only fills the temporary byte. Writing the low byte then sends the full word `{temporary, data}` to the core as a single-cycle strobe.

The bridge also holds the three control bytes and the three 16-bit compare words. Software reads and writes these one byte at a time, with no staging. The 4-bit timer mode is taken from two control-byte fields. The top/capture word can only be written while that mode is 12. In any other mode, writes to either byte of the top/capture pair have no effect at all. Read data and the commit strobes are registered, so each appears in the cycle after the bus request.

Top module: `timer_word_bridge`

## Requirements
- R1: After reset, `bus_rdata` is 0, both commit strobes are low, all control and compare bytes are 0, and the temporary byte is 0 (a high-byte read of offset 5 returns 0).
- R2: A read of offset 4 returns `cnt_live[7:0]` and latches `cnt_live[15:8]` into the temporary byte. A read of offset 5 returns the temporary byte, even if `cnt_live` has changed since the latch.
- R3: A write to offset 5 loads only the temporary byte. It raises no strobe and changes no other register.
- R4: A write of byte D to offset 4 raises `cnt_wr_stb` for exactly the following cycle, with `cnt_wr_word = {temporary, D}`.
- R5: The top/capture pair (low byte at 6, high byte at 7) uses the same temporary byte and the same read and write ordering, with `top_live`, `top_wr_stb` and `top_wr_word`. A high byte staged through one pair is committed by a low-byte write to the other.
- R6: The mode is `{ctrl_b[4:3], ctrl_a[1:0]}`. Writes to offsets 6 and 7 take effect only while the mode equals 12. Otherwise they raise no strobe and leave the temporary byte unchanged.
- R7: Compare word i (i = 0..2) is stored directly, with its low byte at offset 8+2i and its high byte at 9+2i. It can be read back byte by byte and appears on `cmp_words[16i+15:16i]`.
- R8: Control bytes at offsets 0, 1 and 2 are stored directly, read back unchanged, and drive `ctrl_a`, `ctrl_b` and `ctrl_c`.
- R9: Offsets 3 and 14 or higher are unmapped. Reads of them return 0, and writes to them change no output and no stored byte.
- R10: When reset is asserted in the same cycle as a bus write, reset wins: the written register stays 0 and no strobe is raised.
- R11: `bus_rdata` changes only in the cycle after a read request and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | BYTE_W | Write byte |
| bus_rdata | output | BYTE_W | Registered read byte |
| cnt_live | input | 2*BYTE_W | Live counter value from the core |
| cnt_wr_stb | output | 1 | One-cycle counter load strobe |
| cnt_wr_word | output | 2*BYTE_W | Counter load word |
| top_live | input | 2*BYTE_W | Live top/capture value from the core |
| top_wr_stb | output | 1 | One-cycle top/capture load strobe |
| top_wr_word | output | 2*BYTE_W | Top/capture load word |
| ctrl_a | output | BYTE_W | Control byte at offset 0 |
| ctrl_b | output | BYTE_W | Control byte at offset 1 |
| ctrl_c | output | BYTE_W | Control byte at offset 2 |
| cmp_words | output | 3*2*BYTE_W | Compare words A (lowest) to C (highest) |

## Verification
Two functions can land on the same clock edge: reset and a bus write. The bench provokes this by holding a write of 0xFF to a control byte through an edge where reset is also high. The write is judged lost if that byte still reads 0 and no strobe appears. A second same-edge case is a low-byte read that latches the live high half while the core is about to change it. The bench changes `cnt_live` right after the latching read and expects the later high-byte read to return the old half.

// File: rtl/twb_pkg.sv
`timescale 1ns/1ps
package twb_pkg;
  // Byte offsets the bus decodes; their order is fixed by software.
  localparam int CTL_BYTES   = 3;
  localparam int OFS_CNT_LO  = 4;
  localparam int OFS_CNT_HI  = 5;
  localparam int OFS_TOP_LO  = 6;
  localparam int OFS_TOP_HI  = 7;
  localparam int OFS_CMP     = 8;
  localparam int NUM_CMP     = 3;
  localparam int CMP_BYTES   = 2 * NUM_CMP;
  localparam int OFS_END     = OFS_CMP + CMP_BYTES;
  localparam int CTL_IDX_W   = $clog2(CTL_BYTES);
  localparam int CMP_IDX_W   = $clog2(CMP_BYTES);

  // Mode field locations and the mode that unlocks top/capture writes.
  localparam int MODE_LO_LSB = 0;
  localparam int MODE_HI_LSB = 3;
  localparam logic [3:0] MODE_TOP_OPEN = 4'd12;

  typedef struct packed {
    logic                 ctl;
    logic                 cnt_lo;
    logic                 cnt_hi;
    logic                 top_lo;
    logic                 top_hi;
    logic                 cmp;
    logic [CTL_IDX_W-1:0] ctl_idx;
    logic [CMP_IDX_W-1:0] cmp_idx;
  } twb_hit_t;
endpackage

// File: rtl/twb_decode.sv
`timescale 1ns/1ps
module twb_decode
  import twb_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output twb_hit_t          hit
);
  always_comb begin
    hit = '0;
    if (addr < ADDR_W'(CTL_BYTES)) begin
      hit.ctl     = 1'b1;
      hit.ctl_idx = CTL_IDX_W'(addr);
    end else if (addr == ADDR_W'(OFS_CNT_LO)) begin
      hit.cnt_lo = 1'b1;
    end else if (addr == ADDR_W'(OFS_CNT_HI)) begin
      hit.cnt_hi = 1'b1;
    end else if (addr == ADDR_W'(OFS_TOP_LO)) begin
      hit.top_lo = 1'b1;
    end else if (addr == ADDR_W'(OFS_TOP_HI)) begin
      hit.top_hi = 1'b1;
    end else if ((addr >= ADDR_W'(OFS_CMP)) && (addr < ADDR_W'(OFS_END))) begin
      hit.cmp     = 1'b1;
      hit.cmp_idx = CMP_IDX_W'(addr - ADDR_W'(OFS_CMP));
    end
  end
endmodule

// File: rtl/twb_shadow.sv
`timescale 1ns/1ps
module twb_shadow #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_live,
  input  logic [BYTE_W-1:0] live_hi,
  input  logic              load_bus,
  input  logic [BYTE_W-1:0] bus_byte,
  output logic [BYTE_W-1:0] temp_q
);
  // One byte shared by both word pairs; loads are mutually exclusive.
  always_ff @(posedge clk) begin
    if (rst)            temp_q <= '0;
    else if (load_live) temp_q <= live_hi;
    else if (load_bus)  temp_q <= bus_byte;
  end
endmodule

// File: rtl/twb_bytefile.sv
`timescale 1ns/1ps
module twb_bytefile #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 3,
  parameter int IDX_W  = $clog2(NBYTES)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [IDX_W-1:0]         idx,
  input  logic [BYTE_W-1:0]        wdata,
  output logic [NBYTES*BYTE_W-1:0] q
);
  logic [BYTE_W-1:0] q_r [NBYTES];

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)                          q_r[i] <= '0;
      else if (we && idx == IDX_W'(i))  q_r[i] <= wdata;
    end
    assign q[i*BYTE_W +: BYTE_W] = q_r[i];
  end
endmodule

// File: rtl/twb_commit.sv
`timescale 1ns/1ps
module twb_commit #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_go,
  input  logic              top_go,
  input  logic [BYTE_W-1:0] temp,
  input  logic [BYTE_W-1:0] lo_byte,
  output logic              cnt_stb,
  output logic [WORD_W-1:0] cnt_word,
  output logic              top_stb,
  output logic [WORD_W-1:0] top_word
);
  logic [WORD_W-1:0] joined;
  assign joined = {temp, lo_byte};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_stb  <= 1'b0;
      top_stb  <= 1'b0;
      cnt_word <= '0;
      top_word <= '0;
    end else begin
      cnt_stb <= cnt_go;
      top_stb <= top_go;
      if (cnt_go) cnt_word <= joined;
      if (top_go) top_word <= joined;
    end
  end
endmodule

// File: rtl/timer_word_bridge.sv
`timescale 1ns/1ps
module timer_word_bridge
  import twb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              bus_req,
  input  logic                              bus_we,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [BYTE_W-1:0]                 bus_wdata,
  output logic [BYTE_W-1:0]                 bus_rdata,
  input  logic [2*BYTE_W-1:0]               cnt_live,
  output logic                              cnt_wr_stb,
  output logic [2*BYTE_W-1:0]               cnt_wr_word,
  input  logic [2*BYTE_W-1:0]               top_live,
  output logic                              top_wr_stb,
  output logic [2*BYTE_W-1:0]               top_wr_word,
  output logic [BYTE_W-1:0]                 ctrl_a,
  output logic [BYTE_W-1:0]                 ctrl_b,
  output logic [BYTE_W-1:0]                 ctrl_c,
  output logic [NUM_CMP*2*BYTE_W-1:0]       cmp_words
);
  localparam int WORD_W = 2 * BYTE_W;

  twb_hit_t                   hit;
  logic                       wr, rd, top_open;
  logic [3:0]                 mode;
  logic [BYTE_W-1:0]          temp;
  logic [CTL_BYTES*BYTE_W-1:0] ctl_q;
  logic [BYTE_W-1:0]          rd_mux;
  logic [BYTE_W-1:0]          rdata_q;

  assign wr = bus_req & bus_we;
  assign rd = bus_req & ~bus_we;

  twb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .hit  (hit)
  );

  twb_bytefile #(.BYTE_W(BYTE_W), .NBYTES(CTL_BYTES)) u_ctl (
    .clk   (clk),
    .rst   (rst),
    .we    (wr & hit.ctl),
    .idx   (hit.ctl_idx),
    .wdata (bus_wdata),
    .q     (ctl_q)
  );

  twb_bytefile #(.BYTE_W(BYTE_W), .NBYTES(CMP_BYTES)) u_cmp (
    .clk   (clk),
    .rst   (rst),
    .we    (wr & hit.cmp),
    .idx   (hit.cmp_idx),
    .wdata (bus_wdata),
    .q     (cmp_words)
  );

  assign ctrl_a = ctl_q[0*BYTE_W +: BYTE_W];
  assign ctrl_b = ctl_q[1*BYTE_W +: BYTE_W];
  assign ctrl_c = ctl_q[2*BYTE_W +: BYTE_W];

  // Mode gate for the top/capture pair uses the stored control fields.
  assign mode     = {ctrl_b[MODE_HI_LSB +: 2], ctrl_a[MODE_LO_LSB +: 2]};
  assign top_open = (mode == MODE_TOP_OPEN);

  twb_shadow #(.BYTE_W(BYTE_W)) u_tmp (
    .clk       (clk),
    .rst       (rst),
    .load_live (rd & (hit.cnt_lo | hit.top_lo)),
    .live_hi   (hit.cnt_lo ? cnt_live[WORD_W-1:BYTE_W] : top_live[WORD_W-1:BYTE_W]),
    .load_bus  (wr & (hit.cnt_hi | (hit.top_hi & top_open))),
    .bus_byte  (bus_wdata),
    .temp_q    (temp)
  );

  twb_commit #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_cmt (
    .clk      (clk),
    .rst      (rst),
    .cnt_go   (wr & hit.cnt_lo),
    .top_go   (wr & hit.top_lo & top_open),
    .temp     (temp),
    .lo_byte  (bus_wdata),
    .cnt_stb  (cnt_wr_stb),
    .cnt_word (cnt_wr_word),
    .top_stb  (top_wr_stb),
    .top_word (top_wr_word)
  );

  always_comb begin
    rd_mux = '0;
    if (hit.ctl)         rd_mux = ctl_q[int'(hit.ctl_idx)*BYTE_W +: BYTE_W];
    else if (hit.cnt_lo) rd_mux = cnt_live[BYTE_W-1:0];
    else if (hit.top_lo) rd_mux = top_live[BYTE_W-1:0];
    else if (hit.cnt_hi || hit.top_hi) rd_mux = temp;
    else if (hit.cmp)    rd_mux = cmp_words[int'(hit.cmp_idx)*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata_q <= '0;
    else if (rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/twb_checks.sv
`timescale 1ns/1ps
module twb_checks #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bus_req,
  input logic                    bus_we,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [BYTE_W-1:0]       bus_wdata,
  input logic [BYTE_W-1:0]       bus_rdata,
  input logic                    cnt_wr_stb,
  input logic [2*BYTE_W-1:0]     cnt_wr_word,
  input logic                    top_wr_stb,
  input logic [2*BYTE_W-1:0]     top_wr_word,
  input logic [BYTE_W-1:0]       ctrl_a,
  input logic [BYTE_W-1:0]       ctrl_b,
  input logic [BYTE_W-1:0]       ctrl_c,
  input logic [6*BYTE_W-1:0]     cmp_words
);
  logic unmapped;
  logic [3:0] mode;
  logic past_rst_q;

  assign unmapped = (bus_addr == ADDR_W'(3)) || (bus_addr >= ADDR_W'(14));
  assign mode     = {ctrl_b[4:3], ctrl_a[1:0]};

  always_ff @(posedge clk) begin
    past_rst_q <= rst;
    if (past_rst_q) begin
      AST_RST_CLEAR: assert (!cnt_wr_stb && !top_wr_stb && bus_rdata == '0 &&
                             ctrl_a == '0 && ctrl_b == '0 && ctrl_c == '0 &&
                             cmp_words == '0); // R1 R10
    end
  end

  AST_CNT_COMMIT: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_req && bus_we && bus_addr == ADDR_W'(4)) && !$past(rst))
      |-> (cnt_wr_stb && cnt_wr_word[BYTE_W-1:0] == $past(bus_wdata))); // R4

  AST_CNT_STB_CAUSE: assert property (@(posedge clk) disable iff (rst)
    cnt_wr_stb |-> $past(bus_req && bus_we && bus_addr == ADDR_W'(4))); // R4

  AST_TOP_GATED: assert property (@(posedge clk) disable iff (rst)
    top_wr_stb |-> ($past(mode == 4'd12 && bus_req && bus_we && bus_addr == ADDR_W'(6))
                    && top_wr_word[BYTE_W-1:0] == $past(bus_wdata))); // R6

  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_req && unmapped) && !$past(rst))
      |-> (!cnt_wr_stb && !top_wr_stb && $stable(ctrl_a) && $stable(ctrl_b) &&
           $stable(ctrl_c) && $stable(cmp_words))); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_req && !bus_we && unmapped) && !$past(rst)) |-> (bus_rdata == '0)); // R9

  AST_CMP_DIRECT: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_req && bus_we && bus_addr == ADDR_W'(8)) && !$past(rst))
      |-> (cmp_words[BYTE_W-1:0] == $past(bus_wdata))); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(!(bus_req && !bus_we)) && !$past(rst)) |-> $stable(bus_rdata)); // R11
endmodule

bind timer_word_bridge twb_checks #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_twb_checks (
  .clk         (clk),
  .rst         (rst),
  .bus_req     (bus_req),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .cnt_wr_stb  (cnt_wr_stb),
  .cnt_wr_word (cnt_wr_word),
  .top_wr_stb  (top_wr_stb),
  .top_wr_word (top_wr_word),
  .ctrl_a      (ctrl_a),
  .ctrl_b      (ctrl_b),
  .ctrl_c      (ctrl_c),
  .cmp_words   (cmp_words)
);

// File: tb/timer_word_bridge_test.sv
`timescale 1ns/1ps
module timer_word_bridge_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] cnt_live = 16'h0000;
  logic        cnt_wr_stb;
  logic [15:0] cnt_wr_word;
  logic [15:0] top_live = 16'h0000;
  logic        top_wr_stb;
  logic [15:0] top_wr_word;
  logic [7:0]  ctrl_a, ctrl_b, ctrl_c;
  logic [47:0] cmp_words;

  always #2.5 clk = ~clk;

  timer_word_bridge uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_live(cnt_live), .cnt_wr_stb(cnt_wr_stb), .cnt_wr_word(cnt_wr_word),
    .top_live(top_live), .top_wr_stb(top_wr_stb), .top_wr_word(top_wr_word),
    .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .ctrl_c(ctrl_c), .cmp_words(cmp_words)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Bench-side model of the stored bytes.
  logic [7:0] m_ctl [3];
  logic [7:0] m_cmp [6];
  logic [7:0] m_temp;
  logic [7:0] m_rdata;

  task automatic chk(input string tag, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) m_ctl[i] = 8'h00;
    for (int i = 0; i < 6; i++) m_cmp[i] = 8'h00;
    m_temp  = 8'h00;
    m_rdata = 8'h00;
  endtask

  function automatic string tag_for(input int a, input bit we);
    if (a <= 2) return "R8";
    if (a == 3 || a >= 14) return "R9";
    if (a == 4) return we ? "R4" : "R2";
    if (a == 5) return we ? "R3" : "R2";
    if (a == 6 || a == 7) return "R5_R6";
    return "R7";
  endfunction

  task automatic chk_outputs(input string tag);
    chk({tag, "/R8"}, "ctrl_a", {40'h0, ctrl_a}, {40'h0, m_ctl[0]});
    chk({tag, "/R8"}, "ctrl_b", {40'h0, ctrl_b}, {40'h0, m_ctl[1]});
    chk({tag, "/R8"}, "ctrl_c", {40'h0, ctrl_c}, {40'h0, m_ctl[2]});
    chk({tag, "/R7"}, "cmp_words", cmp_words,
        {m_cmp[5], m_cmp[4], m_cmp[3], m_cmp[2], m_cmp[1], m_cmp[0]});
    chk({tag, "/R11"}, "rdata", {40'h0, bus_rdata}, {40'h0, m_rdata});
  endtask

  task automatic access(input int a, input bit we, input logic [7:0] d);
    bit         mode12, exp_cs, exp_ts;
    logic [15:0] exp_cw, exp_tw;
    string      tag;
    tag    = tag_for(a, we);
    mode12 = ({m_ctl[1][4:3], m_ctl[0][1:0]} == 4'd12);
    exp_cs = 0; exp_ts = 0; exp_cw = '0; exp_tw = '0;
    if (!we) begin
      if (a <= 2)                 m_rdata = m_ctl[a];
      else if (a == 4) begin      m_rdata = cnt_live[7:0]; m_temp = cnt_live[15:8]; end
      else if (a == 6) begin      m_rdata = top_live[7:0]; m_temp = top_live[15:8]; end
      else if (a == 5 || a == 7)  m_rdata = m_temp;
      else if (a >= 8 && a <= 13) m_rdata = m_cmp[a-8];
      else                        m_rdata = 8'h00;
    end else begin
      if (a <= 2)                 m_ctl[a] = d;
      else if (a == 4) begin      exp_cs = 1; exp_cw = {m_temp, d}; end
      else if (a == 5)            m_temp = d;
      else if (a == 6 && mode12) begin exp_ts = 1; exp_tw = {m_temp, d}; end
      else if (a == 7 && mode12)  m_temp = d;
      else if (a >= 8 && a <= 13) m_cmp[a-8] = d;
    end
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0;
    chk(tag, "cnt_wr_stb", {47'h0, cnt_wr_stb}, {47'h0, exp_cs});
    chk(tag, "top_wr_stb", {47'h0, top_wr_stb}, {47'h0, exp_ts});
    if (exp_cs) chk("R4", "cnt_wr_word", {32'h0, cnt_wr_word}, {32'h0, exp_cw});
    if (exp_ts) chk("R5", "top_wr_word", {32'h0, top_wr_word}, {32'h0, exp_tw});
    chk_outputs(tag);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired (R1..R11 unfinished)");
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    cnt_live = 16'hA55A;
    top_live = 16'h3CC3;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk_outputs("R1");
    chk("R1", "cnt_wr_stb", {47'h0, cnt_wr_stb}, 48'h0);
    chk("R1", "top_wr_stb", {47'h0, top_wr_stb}, 48'h0);
    rst = 1'b0;
    access(5, 0, 8'h00);          // R1: temp byte reset to 0
    chk("R1", "temp_after_reset", {40'h0, bus_rdata}, 48'h0);

    // R2: latch on low read, stable against live change
    cnt_live = 16'h1234;
    access(4, 0, 8'h00);
    cnt_live = 16'hBEEF;
    access(5, 0, 8'h00);
    chk("R2", "hi_from_latch", {40'h0, bus_rdata}, 48'h12);

    // R5: top pair shares the temp byte
    top_live = 16'h5AC3;
    access(6, 0, 8'h00);
    access(5, 0, 8'h00);
    access(7, 0, 8'h00);

    // R6: mode 0 blocks top writes and leaves temp alone
    access(5, 1, 8'h44);
    access(7, 1, 8'h99);
    access(6, 1, 8'h11);
    access(5, 0, 8'h00);
    chk("R6", "temp_kept", {40'h0, bus_rdata}, 48'h44);

    // R5/R6: mode 12 opens the top pair; cross-pair staging
    access(1, 1, 8'h18);
    access(0, 1, 8'h00);
    access(5, 1, 8'h77);
    access(6, 1, 8'h11);
    access(7, 1, 8'hAB);
    access(4, 1, 8'hCD);
    chk("R5", "cross_commit", {32'h0, cnt_wr_word}, 48'hABCD);

    // Near-exhaustive sweep over all 16 offsets, write then read
    for (int k = 0; k < 6; k++) begin
      for (int a = 0; a < 16; a++) begin
        logic [7:0] d;
        d = 8'(a * 29 + k * 71 + 3);
        cnt_live = {~d, d ^ 8'h5C};
        top_live = {d ^ 8'h33, ~d};
        access(a, 1, d);
        access(a, 0, 8'h00);
        access(15 - a, 0, 8'h00);
      end
    end

    // R10: reset and a write on the same edge
    @(negedge clk);
    rst = 1'b1; bus_req = 1'b1; bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = 8'hFF;
    @(negedge clk);
    bus_req = 1'b0;
    model_reset();
    chk("R10", "ctrl_a", {40'h0, ctrl_a}, 48'h0);
    chk("R10", "cnt_wr_stb", {47'h0, cnt_wr_stb}, 48'h0);
    rst = 1'b0;
    access(0, 0, 8'h00);
    access(5, 0, 8'h00);

    done = 1;
    summary();
    $finish;
  end
endmodule